// File: doc/BRIEF.md
# Burst Low-Address Sequencer

This block supplies the two lowest address bits for a four-beat burst on a synchronous memory port. When a new access begins, it takes a start value from the two least significant bits of the external address. On each later cycle that asks for the next beat, it steps to the next address of the burst. The caller joins the result with upper address bits that it holds itself. The burst stays inside its aligned group of four and never carries into those upper bits.

A static order input selects one of two orderings:

- **Interleaved:** the start value XOR a beat count, used by processors with cache-line ordering.
- **Linear:** the start value plus the beat count, modulo four.

A clock-enable input freezes the whole sequencer. While it is low, the sequencer ignores every other input.

Top module: `burst_addr_gen`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), `low_addr` reads 0 until the next enabled load or advance.
- R2: On an edge with `clk_en`=1 and `advance`=0, the sequencer loads `seed`. From the next cycle, `low_addr` equals `seed` and the beat count restarts at zero.
- R3: With `interleave`=1, beat k of a burst (k = 0..3) is `seed XOR k`. So seeds 00, 01, 10 and 11 give 00-01-10-11, 01-00-11-10, 10-11-00-01 and 11-10-01-00.
- R4: With `interleave`=0, beat k of a burst is `(seed + k) mod 4`. For example, seed 01 gives 01-10-11-00.
- R5: One edge with `clk_en`=1 and `advance`=1 moves the burst by exactly one beat. After the fourth beat, the next advance returns to the loaded start value, and the output never leaves the aligned group of four.
- R6: On an edge with `clk_en`=0, the start value and the beat count both hold. `low_addr` is unchanged whatever `advance` and `seed` are.
- R7: A load in the middle of a burst abandons it. The following beats count from the new seed with the beat count at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | 1 = act on this edge, 0 = hold all state |
| advance | input | 1 | 1 = step to next beat, 0 = load `seed` |
| interleave | input | 1 | Static order select: 1 = XOR order, 0 = linear wrap |
| seed | input | 2 | Low two bits of the external start address |
| low_addr | output | 2 | Current effective low address bits |

## Verification
`low_addr` is a direct function of the stored start value and the beat count. A wrong value in either register therefore shows on the port in the cycle right after the edge that produced it.

- A beat count that fails to advance, skips a step or misses its wrap shows up in linear mode within one advance as a step other than +1. In interleaved mode it shows up at the latest when the fourth-beat wrap fails to return the seed.
- A start value that is captured wrongly, or that drifts while `clk_en` is low, is visible immediately as an address outside the expected group order.

// File: rtl/burst_pkg.sv
package burst_pkg;

    localparam int unsigned LOW_BITS_DEF = 2;

    typedef enum logic {
        ORDER_LINEAR = 1'b0,
        ORDER_XOR    = 1'b1
    } order_e;

    // Per-edge command decoded from enable and advance
    typedef enum logic [1:0] {
        CMD_HOLD = 2'd0,
        CMD_LOAD = 2'd1,
        CMD_STEP = 2'd2
    } burst_cmd_e;

    function automatic burst_cmd_e decode_cmd(input logic en, input logic adv);
        if (!en)
            return CMD_HOLD;
        return adv ? CMD_STEP : CMD_LOAD;
    endfunction

endpackage

// File: rtl/burst_seed_reg.sv
module burst_seed_reg
    import burst_pkg::*;
#(
    parameter int unsigned W = LOW_BITS_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  burst_cmd_e   cmd,
    input  logic [W-1:0] seed,
    output logic [W-1:0] start_q
);

    always_ff @(posedge clk) begin
        if (rst)
            start_q <= '0;
        else if (cmd == CMD_LOAD)
            start_q <= seed;
    end

    // R2: a load captures the seed
    a_r2_seed_capture: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_LOAD) |=> (start_q == $past(seed)));

    // R6: no change while frozen
    a_r6_start_hold: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_HOLD) |=> $stable(start_q));

endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
    import burst_pkg::*;
#(
    parameter int unsigned W = LOW_BITS_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  burst_cmd_e   cmd,
    output logic [W-1:0] beat_q
);

    localparam logic [W-1:0] STEP = W'(1);

    logic [W-1:0] beat_d;

    always_comb begin
        unique case (cmd)
            CMD_LOAD: beat_d = '0;
            CMD_STEP: beat_d = beat_q + STEP;  // natural wrap within group
            default:  beat_d = beat_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            beat_q <= '0;
        else
            beat_q <= beat_d;
    end

    // R7: load restarts the beat count
    a_r7_beat_restart: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_LOAD) |=> (beat_q == '0));

    // R6: beat count frozen when disabled
    a_r6_beat_hold: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_HOLD) |=> $stable(beat_q));

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
    import burst_pkg::*;
#(
    parameter int unsigned W = LOW_BITS_DEF
) (
    input  order_e       order,
    input  logic [W-1:0] start,
    input  logic [W-1:0] beat,
    output logic [W-1:0] addr
);

    logic [W-1:0] xor_addr;
    logic [W-1:0] lin_addr;

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_xor_bit
            assign xor_addr[i] = start[i] ^ beat[i];
        end
    endgenerate

    assign lin_addr = start + beat;  // drops carry: stays in the aligned group

    always_comb begin
        addr = (order == ORDER_XOR) ? xor_addr : lin_addr;
    end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int unsigned LOW_BITS = LOW_BITS_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clk_en,
    input  logic                advance,
    input  logic                interleave,
    input  logic [LOW_BITS-1:0] seed,
    output logic [LOW_BITS-1:0] low_addr
);

    localparam logic [LOW_BITS-1:0] ONE = LOW_BITS'(1);

    burst_cmd_e          cmd;
    order_e              order;
    logic [LOW_BITS-1:0] start_q;
    logic [LOW_BITS-1:0] beat_q;

    assign cmd   = decode_cmd(clk_en, advance);
    assign order = order_e'(interleave);

    burst_seed_reg #(.W(LOW_BITS)) u_seed (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .seed    (seed),
        .start_q (start_q)
    );

    burst_beat_ctr #(.W(LOW_BITS)) u_beat (
        .clk    (clk),
        .rst    (rst),
        .cmd    (cmd),
        .beat_q (beat_q)
    );

    burst_order_map #(.W(LOW_BITS)) u_map (
        .order (order),
        .start (start_q),
        .beat  (beat_q),
        .addr  (low_addr)
    );

    // R4: linear order moves by +1 mod group per advance
    a_r4_linear_step: assert property (@(posedge clk) disable iff (rst)
        (clk_en && advance && !interleave) |=> (low_addr == $past(low_addr) + ONE));

    // R3: interleaved order always moves to a different address per advance
    a_r3_xor_moves: assert property (@(posedge clk) disable iff (rst)
        (clk_en && advance && interleave) |=> (low_addr != $past(low_addr)));

    // R6: output frozen while disabled
    a_r6_out_hold: assert property (@(posedge clk) disable iff (rst)
        !clk_en |=> $stable(low_addr));

    // R2: first address after a load is the seed itself
    a_r2_load_visible: assert property (@(posedge clk) disable iff (rst)
        (clk_en && !advance) |=> (low_addr == $past(seed)));

endmodule

// File: tb/tb_burst_addr_gen.sv
module tb_burst_addr_gen;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       clk_en;
    logic       advance;
    logic       interleave;
    logic [1:0] seed;
    logic [1:0] low_addr;

    int total = 0;
    int bad   = 0;

    // bench model
    logic [1:0] m_start;
    logic [1:0] m_beat;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_addr_gen dut (
        .clk        (clk),
        .rst        (rst),
        .clk_en     (clk_en),
        .advance    (advance),
        .interleave (interleave),
        .seed       (seed),
        .low_addr   (low_addr)
    );

    function automatic logic [1:0] expect_addr(input logic il, input logic [1:0] s,
                                               input logic [1:0] k);
        logic [2:0] sum;
        if (il)
            return s ^ k;
        sum = {1'b0, s} + {1'b0, k};
        return sum[1:0];
    endfunction

    task automatic check(input string tag, input logic [1:0] exp);
        total++;
        if (low_addr !== exp) begin
            bad++;
            $display("FAIL %s: low_addr=%b expected=%b", tag, low_addr, exp);
        end
    endtask

    // drive at negedge, update model at posedge, check at next negedge
    task automatic step(input logic en, input logic adv, input logic [1:0] sd,
                        input string tag);
        clk_en  = en;
        advance = adv;
        seed    = sd;
        @(posedge clk);
        if (en) begin
            if (!adv) begin
                m_start = sd;
                m_beat  = 2'd0;
            end else begin
                m_beat = m_beat + 2'd1;
            end
        end
        @(negedge clk);
        check(tag, expect_addr(interleave, m_start, m_beat));
    endtask

    task automatic do_reset(input logic il);
        interleave = il;
        rst = 1'b1;
        clk_en = 1'b1;
        advance = 1'b0;
        seed = 2'b11;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_start = 2'd0;
        m_beat  = 2'd0;
        check("R1 reset", 2'b00);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        total++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd12345));
        rst = 1'b1;
        clk_en = 1'b0;
        advance = 1'b0;
        seed = 2'b00;
        interleave = 1'b1;
        @(negedge clk);

        for (int mode = 1; mode >= 0; mode--) begin
            do_reset(mode[0]);
            // R1: advance from reset keeps working from start 0
            step(1'b1, 1'b1, 2'b10, "R1 first advance after reset");
            // R3/R4 + R5 full burst and wrap for every seed
            for (int s = 0; s < 4; s++) begin
                step(1'b1, 1'b0, s[1:0], "R2 load");
                for (int k = 0; k < 5; k++)
                    step(1'b1, 1'b1, 2'(~s), mode ? "R3 xor beat / R5 wrap"
                                                  : "R4 linear beat / R5 wrap");
            end
            // R6: freeze mid-burst with stray load request
            step(1'b1, 1'b0, 2'b01, "R2 load");
            step(1'b1, 1'b1, 2'b00, "R5 advance");
            step(1'b0, 1'b0, 2'b10, "R6 hold despite load");
            step(1'b0, 1'b1, 2'b11, "R6 hold despite advance");
            step(1'b1, 1'b1, 2'b00, "R6 resume");
            // R7: reload mid-burst
            step(1'b1, 1'b0, 2'b11, "R7 reload");
            step(1'b1, 1'b1, 2'b00, "R7 count from new seed");
            // random mix
            for (int n = 0; n < 400; n++) begin
                logic en;
                logic adv;
                en  = ($urandom % 4) != 0;
                adv = ($urandom % 3) != 0;
                step(en, adv, 2'($urandom),
                     !en ? "R6 random hold" : (!adv ? "R2 random load"
                          : (mode ? "R3 random" : "R4 random")));
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule